// File: doc/BRIEF.md
# Two-Bit Cursor Overlay

This block places a 64x64 pixel hardware cursor over a pixel stream that has already been turned into RGB. Each incoming pixel carries its own X/Y screen coordinates and a valid flag. When a pixel falls inside the cursor window, a two-bit code taken from a pattern store decides what comes out: the original pixel, or one of three programmable cursor colours. Pixels outside the window, and all pixels while the cursor is switched off, come out unchanged. The output is registered, so every pixel leaves exactly one clock after it enters.

Software programs the block through a simple register port with a select field. One space holds pattern words, each packing eight two-bit codes. One holds the three 24-bit cursor colours. One holds the window position. Writes take effect for the very next pixel. Each pattern word is written in a single cycle, so no pixel can ever see half of a code. Read data comes back one cycle after the address is presented.

Top module: `cursor_overlay`

## Requirements
- R1: For every clock, out_valid, out_x and out_y equal in_valid, in_x and in_y from the previous clock. out_rgb always carries the overlay result for the pixel presented one clock earlier.
- R2: The window covers X from PX to PX+63 and Y from PY to PY+63. PX is position bits 23:12 and PY is position bits 11:0. Any pixel outside that range passes through unchanged. The comparison does not wrap, so a window that runs past coordinate 4095 does not reappear near 0.
- R3: A pixel with offsets dx = x-PX and dy = y-PY inside the window uses pattern word dy*8 + dx/8. Its code sits at bits (dx mod 8)*2+1 down to (dx mod 8)*2 of that word.
- R4: Code 0 outputs in_rgb unchanged. Codes 1, 2 and 3 output cursor colour entries 0, 1 and 2.
- R5: A cursor colour entry is 24-bit RGB, with red in bits 23:16, green in 15:8 and blue in 7:0. The entry is output exactly as written.
- R6: While cursor_off is high, every pixel passes through unchanged, including pixels inside the window.
- R7: Reset clears all 512 pattern words, the three colour entries and the position register to zero. It also drives out_valid low.
- R8: reg_sel selects the space: 0 = pattern (index 0..511, data bits 15:0), 1 = colour (index 0..2), 2 = position, 3 = none. reg_rdata returns the selected value one clock after reg_sel/reg_idx are presented, and a pattern word is zero-extended. A write to colour index 3 or above, or to select 3, changes nothing, and those addresses read as zero.
- R9: A register write performed on one clock edge affects a pixel presented in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cursor_off | input | 1 | Forces all pixels to pass through |
| in_valid | input | 1 | Input pixel valid |
| in_x | input | 12 | Input pixel X coordinate |
| in_y | input | 12 | Input pixel Y coordinate |
| in_rgb | input | 24 | Input pixel colour |
| out_valid | output | 1 | Output pixel valid |
| out_x | output | 12 | Output pixel X coordinate |
| out_y | output | 12 | Output pixel Y coordinate |
| out_rgb | output | 24 | Output pixel colour after overlay |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register space select |
| reg_idx | input | 9 | Word or entry index within the space |
| reg_wdata | input | 24 | Register write data |
| reg_rdata | output | 24 | Register read data, one cycle after address |

## Verification
The hardest conditions to reach from the ports are the window edges: the last word of the pattern store, and a window that overhangs the 4095 coordinate limit. A wrapping comparison there would silently light pixels near the origin. The stimulus moves the window to X=Y=4090, plants a code at offset (5,5), and then probes (4095,4095), (3,3) and a pixel just left of the window. A separate case places the window at (100,50) and probes offset (63,63) together with the pixels one step beyond it on the right and below, which exercises word 511 and its top bit pair.

// File: rtl/cursor_overlay.sv
module cursor_overlay #(
  parameter int CW  = 8,
  parameter int XYW = 12,
  parameter int CUR = 64,
  parameter int PW  = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cursor_off,
  input  logic                 in_valid,
  input  logic [XYW-1:0]       in_x,
  input  logic [XYW-1:0]       in_y,
  input  logic [3*CW-1:0]      in_rgb,
  output logic                 out_valid,
  output logic [XYW-1:0]       out_x,
  output logic [XYW-1:0]       out_y,
  output logic [3*CW-1:0]      out_rgb,
  input  logic                 reg_we,
  input  logic [1:0]           reg_sel,
  input  logic [$clog2(CUR*CUR*2/PW)-1:0] reg_idx,
  input  logic [((2*XYW > 3*CW) ? 2*XYW : 3*CW)-1:0] reg_wdata,
  output logic [((2*XYW > 3*CW) ? 2*XYW : 3*CW)-1:0] reg_rdata
);
  localparam int RGBW  = 3*CW;
  localparam int POSW  = 2*XYW;
  localparam int DW    = (POSW > RGBW) ? POSW : RGBW;
  localparam int CPW   = PW/2;
  localparam int DEPTH = CUR*CUR/CPW;
  localparam int AW    = $clog2(DEPTH);
  localparam int OFFW  = $clog2(CUR);
  localparam int LW    = $clog2(CPW);

  logic [PW-1:0]   pat_q [DEPTH];
  logic [RGBW-1:0] col_q [3];
  logic [POSW-1:0] pos_q;

  wire [XYW-1:0] pos_x = pos_q[POSW-1:XYW];
  wire [XYW-1:0] pos_y = pos_q[XYW-1:0];

  wire [XYW:0] dx = {1'b0, in_x} - {1'b0, pos_x};
  wire [XYW:0] dy = {1'b0, in_y} - {1'b0, pos_y};

  wire in_win = !dx[XYW] && (dx[XYW-1:OFFW] == '0) &&
                !dy[XYW] && (dy[XYW-1:OFFW] == '0);

  wire [AW-1:0] widx = {dy[OFFW-1:0], dx[OFFW-1:LW]};
  wire [PW-1:0] word = pat_q[widx];
  wire [1:0]    code = word[{dx[LW-1:0], 1'b0} +: 2];

  logic [RGBW-1:0] mix;
  always_comb begin
    mix = in_rgb;
    if (in_win && !cursor_off && code != 2'd0)
      mix = col_q[code - 2'd1];
  end

  wire col_ok = (reg_idx < 3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) pat_q[i] <= '0;
      for (int i = 0; i < 3; i++) col_q[i] <= '0;
      pos_q <= '0;
    end else if (reg_we) begin
      case (reg_sel)
        2'd0: pat_q[reg_idx] <= reg_wdata[PW-1:0];
        2'd1: if (col_ok) col_q[reg_idx[1:0]] <= reg_wdata[RGBW-1:0];
        2'd2: pos_q <= reg_wdata[POSW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata <= '0;
    end else begin
      case (reg_sel)
        2'd0:    reg_rdata <= DW'(pat_q[reg_idx]);
        2'd1:    reg_rdata <= col_ok ? DW'(col_q[reg_idx[1:0]]) : '0;
        2'd2:    reg_rdata <= DW'(pos_q);
        default: reg_rdata <= '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_x     <= '0;
      out_y     <= '0;
      out_rgb   <= '0;
    end else begin
      out_valid <= in_valid;
      out_x     <= in_x;
      out_y     <= in_y;
      out_rgb   <= mix;
    end
  end
endmodule

module cursor_overlay_chk #(
  parameter int XYW  = 12,
  parameter int RGBW = 24
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cursor_off,
  input logic            in_valid,
  input logic [XYW-1:0]  in_x,
  input logic [XYW-1:0]  in_y,
  input logic [RGBW-1:0] in_rgb,
  input logic            out_valid,
  input logic [XYW-1:0]  out_x,
  input logic [XYW-1:0]  out_y,
  input logic [RGBW-1:0] out_rgb,
  input logic [2*XYW-1:0] pos,
  input logic [RGBW-1:0] c0,
  input logic [RGBW-1:0] c1,
  input logic [RGBW-1:0] c2
);
  assert_valid_delay_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> out_valid == $past(in_valid));

  assert_coord_delay_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(in_valid)) |-> (out_x == $past(in_x) && out_y == $past(in_y)));

  assert_left_above_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(in_valid) &&
     ($past(in_x) < $past(pos[2*XYW-1:XYW]) || $past(in_y) < $past(pos[XYW-1:0])))
    |-> out_rgb == $past(in_rgb));

  assert_colour_choice_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(in_valid)) |->
    (out_rgb == $past(in_rgb) || out_rgb == $past(c0) ||
     out_rgb == $past(c1) || out_rgb == $past(c2)));

  assert_off_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(in_valid) && $past(cursor_off)) |-> out_rgb == $past(in_rgb));
endmodule

bind cursor_overlay cursor_overlay_chk #(.XYW(XYW), .RGBW(3*CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cursor_off(cursor_off),
  .in_valid(in_valid), .in_x(in_x), .in_y(in_y), .in_rgb(in_rgb),
  .out_valid(out_valid), .out_x(out_x), .out_y(out_y), .out_rgb(out_rgb),
  .pos(pos_q), .c0(col_q[0]), .c1(col_q[1]), .c2(col_q[2])
);

// File: tb/cursor_overlay_tb.sv
module cursor_overlay_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cursor_off = 0;
  logic        in_valid = 0;
  logic [11:0] in_x = 0, in_y = 0;
  logic [23:0] in_rgb = 0;
  logic        out_valid;
  logic [11:0] out_x, out_y;
  logic [23:0] out_rgb;
  logic        reg_we = 0;
  logic [1:0]  reg_sel = 0;
  logic [8:0]  reg_idx = 0;
  logic [23:0] reg_wdata = 0;
  logic [23:0] reg_rdata;

  int checks = 0, errors = 0;
  bit done = 0;

  localparam logic [23:0] C0 = 24'hFF0000, C1 = 24'h00FF00, C2 = 24'h0000FF;

  always #10 clk = ~clk;

  cursor_overlay u_dut (.*);

  task automatic check(input bit ok, input string tag, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input int idx, input logic [23:0] d);
    @(negedge clk);
    reg_we = 1; reg_sel = s; reg_idx = 9'(idx); reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input logic [1:0] s, input int idx, input logic [23:0] exp, input string tag);
    @(negedge clk);
    reg_we = 0; reg_sel = s; reg_idx = 9'(idx);
    @(negedge clk);
    check(reg_rdata == exp, tag, reg_rdata, exp);
  endtask

  task automatic pix(input int x, input int y, input logic [23:0] rgb, input logic [23:0] exp, input string tag);
    @(negedge clk);
    in_valid = 1; in_x = 12'(x); in_y = 12'(y); in_rgb = rgb;
    @(negedge clk);
    in_valid = 0;
    check(out_valid && out_x == 12'(x) && out_y == 12'(y), {tag, " R1 coords"}, {out_x, out_y}, {12'(x), 12'(y)});
    check(out_rgb == exp, tag, out_rgb, exp);
  endtask

  function automatic logic [23:0] posv(input int x, input int y);
    return {12'(x), 12'(y)};
  endfunction

  task automatic t_reset;
    check(out_valid == 0, "R7 out_valid in reset", {23'd0, out_valid}, 0);
    rd(0, 25, 0, "R7 pattern cleared");
    rd(1, 0, 0, "R7 colour cleared");
    rd(2, 0, 0, "R7 position cleared");
    pix(0, 0, 24'h123456, 24'h123456, "R7 empty pattern passes");
    @(negedge clk);
    check(out_valid == 0, "R1 idle valid low", {23'd0, out_valid}, 0);
  endtask

  task automatic t_program;
    wr(1, 0, C0); wr(1, 1, C1); wr(1, 2, C2);
    wr(2, 0, posv(100, 50));
    wr(0, 25, 24'h0039);
    pix(108, 53, 24'hAAAAAA, C0, "R4 code1 colour0");
    pix(109, 53, 24'hAAAAAA, C1, "R4 code2 colour1");
    pix(110, 53, 24'hAAAAAA, C2, "R3 code3 at bits 5:4");
    pix(111, 53, 24'hABCDEF, 24'hABCDEF, "R4 code0 passes");
  endtask

  task automatic t_edges;
    wr(0, 511, 24'h4000);
    pix(163, 113, 24'h111111, C0, "R3 last word top pair");
    pix(164, 113, 24'h222222, 24'h222222, "R2 right of window");
    pix(163, 114, 24'h333333, 24'h333333, "R2 below window");
    pix(99, 53, 24'h444444, 24'h444444, "R2 left of window");
    pix(100, 50, 24'h555555, 24'h555555, "R3 word0 code0");
    wr(0, 0, 24'h0003);
    pix(100, 50, 24'h555555, C2, "R9 write seen next pixel");
  endtask

  task automatic t_off;
    cursor_off = 1;
    pix(110, 53, 24'h0F0F0F, 24'h0F0F0F, "R6 off passes");
    cursor_off = 0;
    pix(110, 53, 24'h0F0F0F, C2, "R6 back on");
  endtask

  task automatic t_readback;
    rd(0, 25, 24'h000039, "R8 pattern read");
    rd(1, 1, C1, "R5 colour read RGB");
    rd(2, 0, posv(100, 50), "R8 position read");
    wr(1, 3, 24'h777777);
    rd(1, 3, 0, "R8 colour idx3 reads zero");
    wr(3, 0, 24'h888888);
    rd(3, 0, 0, "R8 select3 reads zero");
    rd(1, 0, C0, "R8 colour0 untouched");
    rd(2, 0, posv(100, 50), "R8 position untouched");
    wr(1, 0, 24'h123456);
    pix(108, 53, 24'h000000, 24'h123456, "R5 colour exact");
  endtask

  task automatic t_overhang;
    wr(2, 0, posv(4090, 4090));
    wr(0, 40, 24'h0800);
    pix(4095, 4095, 24'h999999, C1, "R2 overhang inside");
    pix(3, 3, 24'h010101, 24'h010101, "R2 no wrap");
    pix(4089, 4095, 24'h020202, 24'h020202, "R2 left of overhang");
  endtask

  task automatic t_rereset;
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    rd(0, 25, 0, "R7 reset clears pattern");
    rd(1, 1, 0, "R7 reset clears colour");
    rd(2, 0, 0, "R7 reset clears position");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_program();
    t_edges();
    t_off();
    t_readback();
    t_overhang();
    t_rereset();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule